// File: doc/BRIEF.md
# Coprocessor Bus Hand-Over Arbiter

This block decides who drives a coprocessor's memory port: the coprocessor core itself, or a host processor reaching in through an address window. The host controls the exchange through three small registers: it raises a hold request, waits for the status bit to show the bus is free, then reads and writes the coprocessor's memory. The core only gives up the bus at its own access boundaries (fetches, data accesses, I/O, wait states). Once it gives up the bus it stays frozen until the host withdraws the request.

The host also has a run-enable bit. While the bit is clear the core neither advances nor takes interrupts. Moving the bit from one to zero sends the core a one-cycle reset strobe and drops any pending hold or hand-over. The block also conditions the core's two interrupt sources. The non-maskable input is latched on a rising edge and consumed once. The maskable line is produced internally: each vertical-blank pulse stretches it to a fixed number of clocks, and it is honoured at every allowed boundary while it stays high and the core's interrupt enable is set.

Top module: `cobus_arbiter`

## Requirements
- R1: Register address 1 holds the hold request and address 2 holds the run enable. Each takes bit 0 of the written byte, bits 7:1 are ignored, and the new value is visible one clock after the write.
- R2: `grant` rises only on a clock where `cp_boundary` is high, the request is set and the enable is set. It therefore rises no earlier than one clock after the request register was set. `cp_go` is low while the request or the grant is set.
- R3: A read of register address 0 returns the inverse of `grant` in bit 0 and zero in bits 7:1. Other addresses read as zero.
- R4: While `grant` is high, `win_rdata` returns `mem_rdata` for a window read, and the window's address, data and write strobe drive the memory port. While `grant` is low, `win_rdata` is zero and a window write does not reach `mem_we`.
- R5: One clock after the request is cleared, `grant` falls and `cp_go` returns high.
- R6: A write of 0 to the enable register while it is 1 pulses `cp_reset` for exactly one clock, clears request and grant, and discards a latched non-maskable interrupt. A write of 0 while it is already 0 gives no pulse.
- R7: A rising edge on `nmi_in` while enabled is latched. It is taken at the next allowed boundary with vector 0x0066, is taken only once, and wins over the maskable interrupt.
- R8: While `int_line` and `cp_iff` are high, every allowed boundary takes the maskable interrupt with vector 0x0038. With `cp_iff` low it is not taken.
- R9: A one-clock `vblank_start` pulse holds `int_line` high for exactly INT_HOLD clocks, starting on the clock after the pulse.
- R10: While the enable is 0, `cp_go` and `irq_take` stay low and edges on `nmi_in` are not latched. After reset the enable and request are 0 and the status bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreg_addr | input | 2 | Host register select: 0 status, 1 request, 2 enable |
| hreg_wr | input | 1 | Host register write strobe |
| hreg_wdata | input | 8 | Host register write data (bit 0 used) |
| hreg_rdata | output | 8 | Host register read data |
| win_rd | input | 1 | Host window read |
| win_wr | input | 1 | Host window write |
| win_addr | input | AW | Host window address |
| win_wdata | input | DW | Host window write data |
| win_rdata | output | DW | Host window read data |
| cp_boundary | input | 1 | Core is at an access boundary |
| cp_iff | input | 1 | Core's maskable interrupt enable |
| cp_addr | input | AW | Core memory address |
| cp_we | input | 1 | Core memory write strobe |
| cp_wdata | input | DW | Core memory write data |
| cp_rdata | output | DW | Memory read data to the core |
| cp_go | output | 1 | Core may proceed past its boundary |
| cp_reset | output | 1 | One-clock core reset strobe |
| grant | output | 1 | Bus handed to the host |
| mem_addr | output | AW | Memory port address |
| mem_we | output | 1 | Memory port write strobe |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Memory port read data |
| nmi_in | input | 1 | Non-maskable interrupt source (edge) |
| vblank_start | input | 1 | Start-of-vertical-blank pulse |
| int_line | output | 1 | Stretched maskable interrupt line |
| irq_take | output | 1 | Interrupt accepted at this boundary |
| irq_vec | output | 16 | Vector of the accepted interrupt |

## Verification
The bench builds the block with AW = 8, DW = 8 and INT_HOLD = 12. The short hold lets the whole stretched maskable window be walked clock by clock. Inside that window the bench mixes a level-taken interrupt, a masked boundary and a non-maskable edge that has to win priority. The memory model returns the bitwise inverse of the address, so a pass-through read can be told apart from the forced zero.

// File: rtl/cobus_pkg.sv
package cobus_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_REQ    = 2'd1,
        REG_EN     = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OWN_CORE = 1'b0,
        OWN_HOST = 1'b1
    } owner_e;

    localparam logic [15:0] NMI_VECTOR = 16'h0066;
    localparam logic [15:0] INT_VECTOR = 16'h0038;

    function automatic logic [15:0] pick_vector(input logic nmi_wins);
        return nmi_wins ? NMI_VECTOR : INT_VECTOR;
    endfunction

endpackage

// File: rtl/cobus_ctrl.sv
module cobus_ctrl
    import cobus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_bit,
    input  logic       cp_boundary,
    output logic [7:0] reg_rdata,
    output logic       en_q,
    output logic       req_q,
    output logic       grant,
    output logic       cp_go,
    output logic       cp_reset,
    output logic       shutdown
);

    owner_e   owner_q;
    reg_sel_e sel;

    assign sel      = reg_sel_e'(reg_addr);
    assign shutdown = reg_wr && (sel == REG_EN) && !reg_bit && en_q;
    assign grant    = (owner_q == OWN_HOST);
    assign cp_go    = en_q && !req_q && !grant;

    always_comb begin
        reg_rdata = 8'h00;
        if (sel == REG_STATUS) reg_rdata[0] = ~grant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            req_q    <= 1'b0;
            owner_q  <= OWN_CORE;
            cp_reset <= 1'b0;
        end else if (shutdown) begin
            en_q     <= 1'b0;
            req_q    <= 1'b0;
            owner_q  <= OWN_CORE;
            cp_reset <= 1'b1;
        end else begin
            cp_reset <= 1'b0;
            if (reg_wr && sel == REG_EN)  en_q  <= reg_bit;
            if (reg_wr && sel == REG_REQ) req_q <= reg_bit;
            unique case (owner_q)
                OWN_CORE: if (cp_boundary && req_q && en_q) owner_q <= OWN_HOST;
                OWN_HOST: if (!req_q)                       owner_q <= OWN_CORE;
                default:                                    owner_q <= OWN_CORE;
            endcase
        end
    end

    p_grant_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> $past(req_q && en_q && cp_boundary));

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (grant && !req_q && !shutdown) |=> !grant);

    p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
        cp_reset |-> (!grant && !req_q && !en_q));

endmodule

// File: rtl/cobus_irq.sv
module cobus_irq
    import cobus_pkg::*;
#(
    parameter int INT_HOLD = 1710
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_q,
    input  logic        shutdown,
    input  logic        cp_go,
    input  logic        cp_boundary,
    input  logic        cp_iff,
    input  logic        nmi_in,
    input  logic        vblank_start,
    output logic        int_line,
    output logic        irq_take,
    output logic [15:0] irq_vec
);

    localparam int CW = $clog2(INT_HOLD + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(INT_HOLD);

    logic [CW-1:0] hold_cnt;
    logic          nmi_prev;
    logic          nmi_pend;
    logic          nmi_rise;
    logic          slot;
    logic          take_nmi;

    assign nmi_rise = nmi_in && !nmi_prev;
    assign int_line = (hold_cnt != '0);
    assign slot     = cp_boundary && cp_go;
    assign take_nmi = slot && nmi_pend;
    assign irq_take = take_nmi || (slot && int_line && cp_iff);
    assign irq_vec  = irq_take ? pick_vector(nmi_pend) : 16'h0000;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (vblank_start) begin
            hold_cnt <= HOLD_LOAD;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            if (shutdown)
                nmi_pend <= 1'b0;
            else
                nmi_pend <= (nmi_pend && !take_nmi) || (nmi_rise && en_q);
        end
    end

    p_nmi_once_r7: assert property (@(posedge clk) disable iff (rst)
        (take_nmi && !nmi_rise) |=> !nmi_pend);

    p_line_starts_r9: assert property (@(posedge clk) disable iff (rst)
        vblank_start |=> int_line);

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !irq_take);

endmodule

// File: rtl/cobus_mux.sv
module cobus_mux
    import cobus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          grant,
    input  logic          win_rd,
    input  logic          win_wr,
    input  logic [AW-1:0] win_addr,
    input  logic [DW-1:0] win_wdata,
    output logic [DW-1:0] win_rdata,
    input  logic [AW-1:0] cp_addr,
    input  logic          cp_we,
    input  logic [DW-1:0] cp_wdata,
    output logic [DW-1:0] cp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    owner_e owner;
    assign owner = grant ? OWN_HOST : OWN_CORE;

    always_comb begin
        unique case (owner)
            OWN_HOST: begin
                mem_addr  = win_addr;
                mem_we    = win_wr;
                mem_wdata = win_wdata;
                win_rdata = win_rd ? mem_rdata : '0;
            end
            default: begin
                mem_addr  = cp_addr;
                mem_we    = cp_we;
                mem_wdata = cp_wdata;
                win_rdata = '0;
            end
        endcase
    end

    assign cp_rdata = mem_rdata;

    always_comb begin
        if (!grant) p_host_blocked_r4: assert (win_rdata == '0);
    end

endmodule

// File: rtl/cobus_arbiter.sv
module cobus_arbiter
    import cobus_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int INT_HOLD = 1710
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    hreg_addr,
    input  logic          hreg_wr,
    input  logic [7:0]    hreg_wdata,
    output logic [7:0]    hreg_rdata,
    input  logic          win_rd,
    input  logic          win_wr,
    input  logic [AW-1:0] win_addr,
    input  logic [DW-1:0] win_wdata,
    output logic [DW-1:0] win_rdata,
    input  logic          cp_boundary,
    input  logic          cp_iff,
    input  logic [AW-1:0] cp_addr,
    input  logic          cp_we,
    input  logic [DW-1:0] cp_wdata,
    output logic [DW-1:0] cp_rdata,
    output logic          cp_go,
    output logic          cp_reset,
    output logic          grant,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          nmi_in,
    input  logic          vblank_start,
    output logic          int_line,
    output logic          irq_take,
    output logic [15:0]   irq_vec
);

    logic en_q;
    logic req_q;
    logic shutdown;
    logic unused_wbits;

    assign unused_wbits = ^hreg_wdata[7:1];

    cobus_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (hreg_addr),
        .reg_wr      (hreg_wr),
        .reg_bit     (hreg_wdata[0]),
        .cp_boundary (cp_boundary),
        .reg_rdata   (hreg_rdata),
        .en_q        (en_q),
        .req_q       (req_q),
        .grant       (grant),
        .cp_go       (cp_go),
        .cp_reset    (cp_reset),
        .shutdown    (shutdown)
    );

    cobus_irq #(.INT_HOLD(INT_HOLD)) u_irq (
        .clk          (clk),
        .rst          (rst),
        .en_q         (en_q),
        .shutdown     (shutdown),
        .cp_go        (cp_go),
        .cp_boundary  (cp_boundary),
        .cp_iff       (cp_iff),
        .nmi_in       (nmi_in),
        .vblank_start (vblank_start),
        .int_line     (int_line),
        .irq_take     (irq_take),
        .irq_vec      (irq_vec)
    );

    cobus_mux #(.AW(AW), .DW(DW)) u_mux (
        .grant     (grant),
        .win_rd    (win_rd),
        .win_wr    (win_wr),
        .win_addr  (win_addr),
        .win_wdata (win_wdata),
        .win_rdata (win_rdata),
        .cp_addr   (cp_addr),
        .cp_we     (cp_we),
        .cp_wdata  (cp_wdata),
        .cp_rdata  (cp_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    p_go_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        (grant || req_q) |-> !cp_go);

    p_disabled_stall_r10: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!cp_go && !grant));

endmodule

// File: tb/cobus_arbiter_tb_top.sv
module cobus_arbiter_tb_top;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int HOLD = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    hreg_addr = 2'd3;
    logic          hreg_wr = 1'b0;
    logic [7:0]    hreg_wdata = 8'h00;
    logic [7:0]    hreg_rdata;
    logic          win_rd = 1'b0;
    logic          win_wr = 1'b0;
    logic [AW-1:0] win_addr = '0;
    logic [DW-1:0] win_wdata = '0;
    logic [DW-1:0] win_rdata;
    logic          cp_boundary = 1'b0;
    logic          cp_iff = 1'b0;
    logic [AW-1:0] cp_addr = 8'h40;
    logic          cp_we = 1'b0;
    logic [DW-1:0] cp_wdata = 8'h11;
    logic [DW-1:0] cp_rdata;
    logic          cp_go;
    logic          cp_reset;
    logic          grant;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          nmi_in = 1'b0;
    logic          vblank_start = 1'b0;
    logic          int_line;
    logic          irq_take;
    logic [15:0]   irq_vec;

    assign mem_rdata = ~mem_addr;

    always #10 clk = ~clk;

    cobus_arbiter #(.AW(AW), .DW(DW), .INT_HOLD(HOLD)) dut_i (.*);

    typedef enum int {
        S_GRANT, S_GO, S_RST, S_STATUS, S_WRD, S_MWE, S_MADDR, S_MWD,
        S_LINE, S_TAKE, S_VEC
    } sig_e;

    typedef struct {
        sig_e        sig;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;

    function automatic logic [31:0] observe(sig_e s);
        case (s)
            S_GRANT:  return 32'(grant);
            S_GO:     return 32'(cp_go);
            S_RST:    return 32'(cp_reset);
            S_STATUS: return 32'(hreg_rdata);
            S_WRD:    return 32'(win_rdata);
            S_MWE:    return 32'(mem_we);
            S_MADDR:  return 32'(mem_addr);
            S_MWD:    return 32'(mem_wdata);
            S_LINE:   return 32'(int_line);
            S_TAKE:   return 32'(irq_take);
            default:  return 32'(irq_vec);
        endcase
    endfunction

    task automatic expect_at(sig_e s, logic [31:0] v, string r);
        item_t it;
        it.sig = s; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    // monitor: compares everything queued in this cycle at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] a;
            it = q.pop_front();
            a = observe(it.sig);
            checks++;
            if (a !== it.exp) begin
                errors++;
                $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, a, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
        hreg_wr = 1'b0;
        win_rd = 1'b0;
        win_wr = 1'b0;
        vblank_start = 1'b0;
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        hreg_addr = a;
        hreg_wdata = d;
        hreg_wr = 1'b1;
    endtask

    bit done = 0;

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        hreg_addr = 2'd0;
        expect_at(S_GRANT, 0, "R10");
        expect_at(S_STATUS, 8'h01, "R10 R3");
        expect_at(S_GO, 0, "R10");
        expect_at(S_LINE, 0, "R10");
        expect_at(S_RST, 0, "R10");

        // R1: bit 0 only
        cyc(); reg_write(2'd2, 8'hFE);
        cyc(); expect_at(S_GO, 0, "R1 upper bits ignored");
        reg_write(2'd2, 8'h01);
        cyc(); expect_at(S_GO, 1, "R1 enable set");

        // R4: no grant -> blocked
        win_rd = 1'b1; win_addr = 8'h05;
        expect_at(S_WRD, 0, "R4 read blocked");
        cyc(); win_wr = 1'b1; win_addr = 8'h09; win_wdata = 8'h33;
        expect_at(S_MWE, 0, "R4 write dropped");
        expect_at(S_MADDR, 8'h40, "R4 core owns port");

        // R2: request, grant only at boundary
        cyc(); reg_write(2'd1, 8'h01);
        expect_at(S_GO, 1, "R2 before request lands");
        cyc(); expect_at(S_GO, 0, "R2 request stalls core");
        expect_at(S_GRANT, 0, "R2 no boundary yet");
        cyc(); expect_at(S_GRANT, 0, "R2 still no boundary");
        cp_boundary = 1'b1;
        expect_at(S_TAKE, 0, "R2 frozen boundary");
        cyc(); cp_boundary = 1'b0; hreg_addr = 2'd0;
        expect_at(S_GRANT, 1, "R2 grant after boundary");
        expect_at(S_STATUS, 8'h00, "R3 status inverted");
        win_rd = 1'b1; win_addr = 8'h05;
        expect_at(S_WRD, 8'hFA, "R4 pass-through read");
        cyc(); win_wr = 1'b1; win_addr = 8'h09; win_wdata = 8'h33;
        expect_at(S_MWE, 1, "R4 host write strobe");
        expect_at(S_MADDR, 8'h09, "R4 host address");
        expect_at(S_MWD, 8'h33, "R4 host data");
        hreg_addr = 2'd3;
        expect_at(S_STATUS, 8'h00, "R3 other address zero");

        // R5 release
        cyc(); reg_write(2'd1, 8'h00);
        cyc(); expect_at(S_GRANT, 1, "R5 grant held one more clock");
        expect_at(S_GO, 0, "R5 core still frozen");
        cyc(); expect_at(S_GRANT, 0, "R5 grant released");
        expect_at(S_GO, 1, "R5 core resumes");

        // R7 NMI
        cyc(); nmi_in = 1'b1;
        cyc(); cp_boundary = 1'b1;
        expect_at(S_TAKE, 1, "R7 nmi taken");
        expect_at(S_VEC, 16'h0066, "R7 nmi vector");
        cyc(); expect_at(S_TAKE, 0, "R7 nmi only once");
        cp_boundary = 1'b0; nmi_in = 1'b0;

        // R9 / R8 / R7 priority within the stretched line
        cyc(); vblank_start = 1'b1;
        for (int i = 0; i < HOLD; i++) begin
            cyc();
            case (i)
                0: begin cp_boundary = 1'b1; cp_iff = 1'b1; end
                1: begin cp_iff = 1'b0; end
                2: begin cp_boundary = 1'b0; nmi_in = 1'b1; end
                3: begin cp_boundary = 1'b1; cp_iff = 1'b1; end
                5: begin cp_boundary = 1'b0; cp_iff = 1'b0; end
                default: ;
            endcase
            expect_at(S_LINE, 1, "R9 line held");
            case (i)
                0: begin expect_at(S_TAKE, 1, "R8 level taken"); expect_at(S_VEC, 16'h0038, "R8 vector"); end
                1: expect_at(S_TAKE, 0, "R8 masked");
                2: expect_at(S_TAKE, 0, "R8 no boundary");
                3: begin expect_at(S_TAKE, 1, "R7 priority"); expect_at(S_VEC, 16'h0066, "R7 nmi wins"); end
                4: begin expect_at(S_TAKE, 1, "R8 level again"); expect_at(S_VEC, 16'h0038, "R8 vector again"); end
                default: ;
            endcase
        end
        cyc(); expect_at(S_LINE, 0, "R9 line drops after hold");
        nmi_in = 1'b0;

        // R6 shutdown while granted, with a latched nmi
        cyc(); reg_write(2'd1, 8'h01); nmi_in = 1'b1;
        cyc(); cp_boundary = 1'b1;
        cyc(); cp_boundary = 1'b0;
        expect_at(S_GRANT, 1, "R6 setup grant");
        reg_write(2'd2, 8'h00);
        cyc(); hreg_addr = 2'd0;
        expect_at(S_RST, 1, "R6 reset pulse");
        expect_at(S_GRANT, 0, "R6 grant cleared");
        expect_at(S_STATUS, 8'h01, "R6 status after reset");
        expect_at(S_GO, 0, "R10 disabled stall");
        cyc(); expect_at(S_RST, 0, "R6 pulse one clock");
        reg_write(2'd2, 8'h00);
        cyc(); expect_at(S_RST, 0, "R6 no pulse on 0 to 0");

        // R10 disabled: no interrupts, edges ignored
        nmi_in = 1'b0; vblank_start = 1'b1;
        cyc(); cp_boundary = 1'b1; cp_iff = 1'b1;
        cyc(); expect_at(S_LINE, 1, "R10 line runs while disabled");
        expect_at(S_TAKE, 0, "R10 no level take");
        nmi_in = 1'b1;
        cyc(); expect_at(S_TAKE, 0, "R10 no nmi take");
        for (int i = 0; i < HOLD + 2; i++) cyc();
        expect_at(S_LINE, 0, "R9 line done");
        reg_write(2'd2, 8'h01);
        cyc(); expect_at(S_GO, 1, "R6 request was cleared");
        expect_at(S_TAKE, 0, "R10 edge not latched; R6 pending dropped");
        cyc(); cp_boundary = 1'b0;
        cyc();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule